// File: doc/BRIEF.md
# Resolver Fault Monitor

This block supervises a resolver-to-digital tracking loop and reports its health on two active-low fault pins, a signal-quality pin and a tracking pin. Each clock it is given a digital magnitude of the demodulated monitor signal, the signed loop error angle, the signed measured velocity and the signed difference between the internal and the external position. From these it finds three kinds of fault: the signal is lost, the signal is degraded, and the loop no longer follows the shaft. It then merges the three into the two pins with a fixed priority.

Some faults hold themselves. A lost signal and an amplitude mismatch between the two resolver channels stay latched until the host clears them with a rising edge on its sample strobe. That same edge also restarts the running minimum and maximum of the monitor magnitude. An over-range magnitude and all tracking faults follow their causes, with no latch. The tracking flag has angle hysteresis: it sets above a high limit and releases only below a low one. The signal thresholds are inputs, so firmware can program them. The angle and velocity limits are build parameters.

Top module: `resolver_fault_monitor`

## Requirements
- R1: A synchronous reset clears every latched fault, sets the stored minimum magnitude to all ones and the stored maximum to zero, and leaves both pins high (no fault) after the reset edge.
- R2: When the magnitude is below the loss threshold (strictly less), both pins go low after that clock edge and stay low until a clear, even if the magnitude recovers. A magnitude equal to the threshold is not a loss.
- R3: When the magnitude is above the over-range threshold (strictly greater), the signal pin is low and the tracking pin is high after that edge. The indication is not latched and ends on the first edge with the magnitude at or below the threshold.
- R4: The block keeps the running minimum and maximum of the magnitude, including the current sample. When maximum minus minimum exceeds the mismatch threshold (strictly greater), the signal pin latches low (tracking pin high) until a clear. A spread equal to the threshold is not a fault.
- R5: A rising edge on the sample input (low in the previous cycle, high now) clears the latched loss and mismatch faults and restarts the minimum and maximum from their reset values, ignoring that cycle's magnitude. A sample input held high clears nothing more.
- R6: The tracking pin goes low (signal pin high) when the absolute loop error exceeds the high angle limit. The default is 57 LSB of a 12-bit angle, close to 5 degrees. An error equal to the limit does not set the fault, and negative errors act through their absolute value.
- R7: Once the tracking fault is set, it clears only on an edge where the absolute error and the absolute position difference are both below the low angle limit (default 11 LSB, close to 1 degree) and the absolute velocity is below the speed limit. Otherwise it holds.
- R8: An absolute position difference above the high angle limit sets the tracking fault just as the loop error does.
- R9: An absolute velocity above the speed limit (default 1000 LSB) sets the tracking fault. A velocity equal to the limit neither sets nor clears it. The tracking fault is never latched and is not cleared by the sample strobe.
- R10: Pin codes (signal pin, tracking pin): 0/0 for loss, 0/1 for degradation (over-range or mismatch), 1/0 for tracking, 1/1 for none. Loss outranks degradation, and degradation outranks tracking. A tracking fault that is hidden by degradation shows again once the degradation ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sample_i | input | 1 | Host sample strobe; its rising edge clears latched faults |
| mag_i | input | MAG_W | Unsigned monitor magnitude |
| los_min_i | input | MAG_W | Loss threshold |
| dos_max_i | input | MAG_W | Over-range threshold |
| span_max_i | input | MAG_W | Allowed max-minus-min spread |
| err_i | input | ANG_W | Signed loop error angle |
| pdiff_i | input | ANG_W | Signed internal/external position difference |
| vel_i | input | VEL_W | Signed velocity |
| dos_n_o | output | 1 | Signal fault pin, active low |
| lot_n_o | output | 1 | Tracking fault pin, active low |

## Verification
The bench drives each threshold to exactly its limit and one step past it. A design that used the wrong comparison (greater-or-equal instead of greater) would flag too early, and the equality cases expose it. It checks that a recovered magnitude keeps loss and mismatch latched, that only a fresh rising edge of the sample strobe releases them, and that a strobe held high does not. A design that cleared on the level, or never cleared, would fail these checks. The bench also walks the tracking flag through its hysteresis band, with negative errors and an overspeed held exactly at the limit, so that a missing band or a sign mistake shows up. Finally, it stacks tracking under degradation and loss to show that the priority encoding hides and then restores the tracking code.

// File: rtl/rfm_pkg.sv
package rfm_pkg;

    typedef struct packed {
        logic lost;
        logic degraded;
        logic tracking;
    } fault_set_t;

    typedef struct packed {
        logic dos_n;
        logic lot_n;
    } pin_pair_t;

    function automatic pin_pair_t encode_pins(input fault_set_t f);
        pin_pair_t p;
        if (f.lost) begin
            p = '{dos_n: 1'b0, lot_n: 1'b0};
        end else if (f.degraded) begin
            p = '{dos_n: 1'b0, lot_n: 1'b1};
        end else if (f.tracking) begin
            p = '{dos_n: 1'b1, lot_n: 1'b0};
        end else begin
            p = '{dos_n: 1'b1, lot_n: 1'b1};
        end
        return p;
    endfunction

endpackage

// File: rtl/rfm_edge_det.sv
module rfm_edge_det (
    input  logic clk,
    input  logic rst,
    input  logic lvl_i,
    output logic rise_o
);
    typedef struct packed {
        logic prev;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.prev = lvl_i;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '{prev: 1'b0};
        else     st_q <= st_d;
    end

    assign rise_o = lvl_i & ~st_q.prev;
endmodule

// File: rtl/rfm_amp_mon.sv
module rfm_amp_mon #(
    parameter int MAG_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr_i,
    input  logic [MAG_W-1:0] mag_i,
    input  logic [MAG_W-1:0] los_min_i,
    input  logic [MAG_W-1:0] dos_max_i,
    input  logic [MAG_W-1:0] span_max_i,
    output logic             lost_o,
    output logic             degraded_o
);
    localparam logic [MAG_W-1:0] MIN_INIT = {MAG_W{1'b1}};
    localparam logic [MAG_W-1:0] MAX_INIT = '0;

    typedef struct packed {
        logic [MAG_W-1:0] lo;
        logic [MAG_W-1:0] hi;
        logic             lost;
        logic             over;
        logic             mism;
    } st_t;

    st_t st_d, st_q;
    logic [MAG_W-1:0] lo_new, hi_new, spread;

    always_comb begin
        lo_new = (mag_i < st_q.lo) ? mag_i : st_q.lo;
        hi_new = (mag_i > st_q.hi) ? mag_i : st_q.hi;
        spread = hi_new - lo_new;

        st_d      = st_q;
        st_d.over = mag_i > dos_max_i;
        if (clr_i) begin
            st_d.lo   = MIN_INIT;
            st_d.hi   = MAX_INIT;
            st_d.lost = 1'b0;
            st_d.mism = 1'b0;
        end else begin
            st_d.lo   = lo_new;
            st_d.hi   = hi_new;
            st_d.lost = st_q.lost | (mag_i < los_min_i);
            st_d.mism = st_q.mism | (spread > span_max_i);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '{lo: MIN_INIT, hi: MAX_INIT, lost: 1'b0, over: 1'b0, mism: 1'b0};
        else     st_q <= st_d;
    end

    assign lost_o     = st_q.lost;
    assign degraded_o = st_q.over | st_q.mism;
endmodule

// File: rtl/rfm_track_mon.sv
module rfm_track_mon #(
    parameter int ANG_W   = 12,
    parameter int VEL_W   = 12,
    parameter int ANG_SET = 57,
    parameter int ANG_REL = 11,
    parameter int VEL_LIM = 1000
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [ANG_W-1:0] err_i,
    input  logic [ANG_W-1:0] pdiff_i,
    input  logic [VEL_W-1:0] vel_i,
    output logic             track_o
);
    localparam logic [ANG_W-1:0] A_ONE = 1;
    localparam logic [VEL_W-1:0] V_ONE = 1;
    localparam logic [ANG_W-1:0] A_SET = ANG_SET[ANG_W-1:0];
    localparam logic [ANG_W-1:0] A_REL = ANG_REL[ANG_W-1:0];
    localparam logic [VEL_W-1:0] V_LIM = VEL_LIM[VEL_W-1:0];

    typedef struct packed {
        logic fault;
    } st_t;

    st_t st_d, st_q;
    logic [ANG_W-1:0] err_abs, pd_abs;
    logic [VEL_W-1:0] vel_abs;
    logic             go_set, go_rel;

    always_comb begin
        err_abs = err_i[ANG_W-1]   ? (~err_i + A_ONE)   : err_i;
        pd_abs  = pdiff_i[ANG_W-1] ? (~pdiff_i + A_ONE) : pdiff_i;
        vel_abs = vel_i[VEL_W-1]   ? (~vel_i + V_ONE)   : vel_i;

        go_set = (err_abs > A_SET) | (pd_abs > A_SET) | (vel_abs > V_LIM);
        go_rel = (err_abs < A_REL) & (pd_abs < A_REL) & (vel_abs < V_LIM);

        st_d = st_q;
        if (go_set)      st_d.fault = 1'b1;
        else if (go_rel) st_d.fault = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '{fault: 1'b0};
        else     st_q <= st_d;
    end

    assign track_o = st_q.fault;
endmodule

// File: rtl/resolver_fault_monitor.sv
module resolver_fault_monitor
    import rfm_pkg::*;
#(
    parameter int MAG_W   = 12,
    parameter int ANG_W   = 12,
    parameter int VEL_W   = 12,
    parameter int ANG_SET = 57,
    parameter int ANG_REL = 11,
    parameter int VEL_LIM = 1000
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sample_i,
    input  logic [MAG_W-1:0] mag_i,
    input  logic [MAG_W-1:0] los_min_i,
    input  logic [MAG_W-1:0] dos_max_i,
    input  logic [MAG_W-1:0] span_max_i,
    input  logic [ANG_W-1:0] err_i,
    input  logic [ANG_W-1:0] pdiff_i,
    input  logic [VEL_W-1:0] vel_i,
    output logic             dos_n_o,
    output logic             lot_n_o
);
    logic       clr;
    fault_set_t faults;
    pin_pair_t  pins;

    rfm_edge_det u_edge (
        .clk    (clk),
        .rst    (rst),
        .lvl_i  (sample_i),
        .rise_o (clr)
    );

    rfm_amp_mon #(.MAG_W(MAG_W)) u_amp (
        .clk        (clk),
        .rst        (rst),
        .clr_i      (clr),
        .mag_i      (mag_i),
        .los_min_i  (los_min_i),
        .dos_max_i  (dos_max_i),
        .span_max_i (span_max_i),
        .lost_o     (faults.lost),
        .degraded_o (faults.degraded)
    );

    rfm_track_mon #(
        .ANG_W   (ANG_W),
        .VEL_W   (VEL_W),
        .ANG_SET (ANG_SET),
        .ANG_REL (ANG_REL),
        .VEL_LIM (VEL_LIM)
    ) u_trk (
        .clk     (clk),
        .rst     (rst),
        .err_i   (err_i),
        .pdiff_i (pdiff_i),
        .vel_i   (vel_i),
        .track_o (faults.tracking)
    );

    always_comb begin
        pins = encode_pins(faults);
    end

    assign dos_n_o = pins.dos_n;
    assign lot_n_o = pins.lot_n;
endmodule

// File: rtl/rfm_checker.sv
module rfm_checker #(
    parameter int MAG_W   = 12,
    parameter int ANG_W   = 12,
    parameter int VEL_W   = 12,
    parameter int ANG_SET = 57,
    parameter int ANG_REL = 11,
    parameter int VEL_LIM = 1000
) (
    input logic             clk,
    input logic             rst,
    input logic             sample_i,
    input logic [MAG_W-1:0] mag_i,
    input logic [MAG_W-1:0] los_min_i,
    input logic [MAG_W-1:0] dos_max_i,
    input logic [MAG_W-1:0] span_max_i,
    input logic [ANG_W-1:0] err_i,
    input logic [ANG_W-1:0] pdiff_i,
    input logic [VEL_W-1:0] vel_i,
    input logic             dos_n_o,
    input logic             lot_n_o
);
    localparam logic [ANG_W-1:0] A_ONE = 1;
    localparam logic [VEL_W-1:0] V_ONE = 1;
    localparam logic [ANG_W-1:0] A_SET = ANG_SET[ANG_W-1:0];
    localparam logic [ANG_W-1:0] A_REL = ANG_REL[ANG_W-1:0];
    localparam logic [VEL_W-1:0] V_LIM = VEL_LIM[VEL_W-1:0];

    logic             smp_q;
    logic             rise;
    logic [ANG_W-1:0] e_abs;
    logic [VEL_W-1:0] v_abs;

    always_ff @(posedge clk) begin
        if (rst) smp_q <= 1'b0;
        else     smp_q <= sample_i;
    end

    assign rise  = sample_i & ~smp_q;
    assign e_abs = err_i[ANG_W-1] ? (~err_i + A_ONE) : err_i;
    assign v_abs = vel_i[VEL_W-1] ? (~vel_i + V_ONE) : vel_i;

    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (dos_n_o && lot_n_o));

    assert_loss_flag_R2: assert property (@(posedge clk) disable iff (rst)
        (mag_i < los_min_i && !rise) |=> (!dos_n_o && !lot_n_o));

    assert_loss_hold_R2: assert property (@(posedge clk) disable iff (rst)
        (!dos_n_o && !lot_n_o && !rise) |=> (!dos_n_o && !lot_n_o));

    assert_over_range_R3: assert property (@(posedge clk) disable iff (rst)
        (mag_i > dos_max_i) |=> !dos_n_o);

    assert_err_set_R6: assert property (@(posedge clk) disable iff (rst)
        (e_abs > A_SET) |=> !(dos_n_o && lot_n_o));

    assert_band_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (!lot_n_o && dos_n_o && e_abs >= A_REL) |=> !(dos_n_o && lot_n_o));

    assert_speed_set_R9: assert property (@(posedge clk) disable iff (rst)
        (v_abs > V_LIM) |=> !(dos_n_o && lot_n_o));
endmodule

bind resolver_fault_monitor rfm_checker #(
    .MAG_W   (MAG_W),
    .ANG_W   (ANG_W),
    .VEL_W   (VEL_W),
    .ANG_SET (ANG_SET),
    .ANG_REL (ANG_REL),
    .VEL_LIM (VEL_LIM)
) u_chk (.*);

// File: tb/resolver_fault_monitor_test.sv
`timescale 1ns/1ps
module resolver_fault_monitor_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sample_i = 1'b0;
    logic [11:0] mag_i = 12'd2000;
    logic [11:0] los_min_i = 12'd400;
    logic [11:0] dos_max_i = 12'd3500;
    logic [11:0] span_max_i = 12'd300;
    logic [11:0] err_i = '0;
    logic [11:0] pdiff_i = '0;
    logic [11:0] vel_i = '0;
    logic        dos_n_o, lot_n_o;

    int n_checks = 0;
    int n_errors = 0;

    always #2.5 clk = ~clk;

    resolver_fault_monitor uut (
        .clk(clk), .rst(rst), .sample_i(sample_i), .mag_i(mag_i),
        .los_min_i(los_min_i), .dos_max_i(dos_max_i), .span_max_i(span_max_i),
        .err_i(err_i), .pdiff_i(pdiff_i), .vel_i(vel_i),
        .dos_n_o(dos_n_o), .lot_n_o(lot_n_o)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic expect_pins(input logic ed, input logic el, input string tag);
        n_checks++;
        if (dos_n_o !== ed || lot_n_o !== el) begin
            n_errors++;
            $display("FAIL %s: pins dos_n/lot_n = %b/%b, expected %b/%b", tag, dos_n_o, lot_n_o, ed, el);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1; sample_i = 1'b0; mag_i = 12'd2000;
        los_min_i = 12'd400; dos_max_i = 12'd3500; span_max_i = 12'd300;
        err_i = '0; pdiff_i = '0; vel_i = '0;
        tick(); tick();
        rst = 1'b0;
        tick();
    endtask

    task automatic test_reset();
        do_reset();
        expect_pins(1, 1, "R1 idle after reset");
        mag_i = 12'd2200; tick();
        expect_pins(1, 1, "R1 min/max restart after reset");
    endtask

    task automatic test_loss();
        do_reset();
        span_max_i = 12'hFFF;
        mag_i = 12'd400; tick();
        expect_pins(1, 1, "R2 magnitude equal to loss threshold");
        mag_i = 12'd399; tick();
        expect_pins(0, 0, "R2 loss flagged");
        mag_i = 12'd2000; tick();
        expect_pins(0, 0, "R2 loss latched after recovery");
        sample_i = 1'b1; tick();
        expect_pins(1, 1, "R5 rising sample clears loss");
        mag_i = 12'd399; tick();
        expect_pins(0, 0, "R2 loss flagged with sample held high");
        mag_i = 12'd2000; tick();
        expect_pins(0, 0, "R5 held-high sample does not clear");
        sample_i = 1'b0; tick();
        expect_pins(0, 0, "R5 falling sample does not clear");
        sample_i = 1'b1; tick();
        expect_pins(1, 1, "R5 second rising sample clears");
        sample_i = 1'b0;
    endtask

    task automatic test_over_range();
        do_reset();
        span_max_i = 12'hFFF;
        mag_i = 12'd3501; tick();
        expect_pins(0, 1, "R3 over-range flagged");
        mag_i = 12'd3500; tick();
        expect_pins(1, 1, "R3 over-range not latched, equal is fine");
    endtask

    task automatic test_mismatch();
        do_reset();
        mag_i = 12'd2300; tick();
        expect_pins(1, 1, "R4 spread equal to threshold");
        mag_i = 12'd1999; tick();
        expect_pins(0, 1, "R4 spread above threshold");
        mag_i = 12'd2000; tick();
        expect_pins(0, 1, "R4 mismatch latched");
        sample_i = 1'b1; tick();
        expect_pins(1, 1, "R5 rising sample clears mismatch");
        sample_i = 1'b0; mag_i = 12'd2300; tick();
        expect_pins(1, 1, "R5 min/max restarted");
        mag_i = 12'd2000; tick();
        expect_pins(1, 1, "R5 new spread at threshold only");
    endtask

    task automatic test_err();
        do_reset();
        err_i = 12'd57; tick();
        expect_pins(1, 1, "R6 error equal to high limit");
        err_i = 12'd58; tick();
        expect_pins(1, 0, "R6 error above high limit");
        err_i = 12'd30; tick();
        expect_pins(1, 0, "R7 hold inside band");
        err_i = 12'd11; tick();
        expect_pins(1, 0, "R7 hold at low limit");
        err_i = 12'd10; tick();
        expect_pins(1, 1, "R7 release below low limit");
        err_i = -12'sd58; tick();
        expect_pins(1, 0, "R6 negative error");
        err_i = -12'sd11; tick();
        expect_pins(1, 0, "R7 negative error holds");
        err_i = '0; tick();
        expect_pins(1, 1, "R7 release at zero");
    endtask

    task automatic test_pdiff();
        do_reset();
        pdiff_i = 12'd58; tick();
        expect_pins(1, 0, "R8 position difference sets");
        pdiff_i = -12'sd20; tick();
        expect_pins(1, 0, "R8 position difference holds in band");
        pdiff_i = -12'sd5; tick();
        expect_pins(1, 1, "R8 position difference released");
    endtask

    task automatic test_speed();
        do_reset();
        vel_i = 12'd1000; tick();
        expect_pins(1, 1, "R9 velocity equal to limit");
        vel_i = 12'd1001; tick();
        expect_pins(1, 0, "R9 overspeed");
        sample_i = 1'b1; tick();
        expect_pins(1, 0, "R9 sample does not clear tracking");
        sample_i = 1'b0;
        vel_i = 12'd1000; tick();
        expect_pins(1, 0, "R9 velocity at limit holds");
        vel_i = 12'd999; tick();
        expect_pins(1, 1, "R7 velocity below limit releases");
        vel_i = -12'sd1001; tick();
        expect_pins(1, 0, "R9 negative overspeed");
        vel_i = '0; tick();
        expect_pins(1, 1, "R9 not latched");
    endtask

    task automatic test_priority();
        do_reset();
        span_max_i = 12'hFFF;
        err_i = 12'd100; tick();
        expect_pins(1, 0, "R10 tracking alone");
        mag_i = 12'd3600; tick();
        expect_pins(0, 1, "R10 degradation hides tracking");
        mag_i = 12'd2000; tick();
        expect_pins(1, 0, "R10 tracking shows again");
        mag_i = 12'd100; tick();
        expect_pins(0, 0, "R10 loss outranks tracking");
        mag_i = 12'd3600; tick();
        expect_pins(0, 0, "R10 loss outranks degradation");
        mag_i = 12'd2000; err_i = '0; tick();
        expect_pins(0, 0, "R10 loss still latched");
        sample_i = 1'b1; tick();
        expect_pins(1, 1, "R10 all clear");
        sample_i = 1'b0;
    endtask

    initial begin
        test_reset();
        test_loss();
        test_over_range();
        test_mismatch();
        test_err();
        test_pdiff();
        test_speed();
        test_priority();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        #100000;
        n_errors++;
        n_checks++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule